// File: doc/BRIEF.md
# Serial ADC Sequencing Controller

This block is the host side of a 16-clock serial link to a four-channel, 12-bit sampling converter. A client raises a request that names an input channel, an input range and the power mode the converter should be left in. The controller turns that into one or two chip-select frames. It builds the 12-bit control word and shifts it out. It generates a divided serial clock and collects the 16-bit word that comes back. It then returns the channel identifier and the 12-bit sample with a one-cycle valid strobe.

The controller keeps its own record of the power mode the converter was last programmed into. When the converter is asleep, the controller first issues the frame needed to wake it. After auto shutdown this is a dummy frame that writes nothing. After full shutdown it is a write back to normal mode, followed by a power-up wait. The data returned by such extra frames is discarded. Between frames the controller enforces a minimum spacing between chip-select falling edges and a quiet gap after each rising edge. All limits are counted in system clocks and set by parameters. A busy output holds off new requests until the whole sequence has finished.

Top module: `adc_seq_ctrl`

## Requirements
- R1: A frame holds `cs_n` low for exactly 16 serial-clock periods. Each period has a low half and then a high half, each `HALF` system clocks long. `sclk` stays high whenever `cs_n` is high.
- R2: The control word goes out MSB first on `mosi`, on the first 12 serial-clock periods, with each bit changing at a falling `sclk` edge. `mosi` is 0 during periods 13 to 16. The word layout is: bit 11 write enable; bits 7:6 channel; bits 5:4 power mode (11 normal, 10 full shutdown, 01 auto shutdown); bit 1 range; all other bits 0.
- R3: Two successive `cs_n` falling edges are at least `T_CYC` system clocks apart.
- R4: A `cs_n` rising edge and the next falling edge are at least `T_QUIET` system clocks apart.
- R5: While the converter is recorded as being in normal mode, a request produces exactly one frame. That frame has the write bit set and carries the requested channel, range and power mode.
- R6: While the converter is recorded as being in auto shutdown, a request first produces a dummy frame with the write bit at 0, whose data is not reported, and then the frame of R5.
- R7: While the converter is recorded as being in full shutdown, a request first produces a wake frame. The wake frame carries the write bit, power mode 11, and the requested channel and range, and its data is not reported. The frame of R5 follows no sooner than `T_PWRUP` system clocks after the wake frame's `cs_n` rising edge.
- R8: `miso` is sampled at each rising `sclk` edge, MSB first, and read as [15:14] leading zeros, [13:12] channel identifier, [11:0] sample. The result of the last frame of a request is reported once, as a one-cycle `res_valid` pulse with `res_chan` and `res_data`.
- R9: `res_err` is high together with `res_valid` exactly when a leading bit is 1 or the identifier differs from the requested channel. Outside `res_valid` it is 0.
- R10: `busy` is high from the cycle after a request is accepted until the sequence has ended. A `req_valid` seen while `busy` is high is ignored.
- R11: After reset, `cs_n` and `sclk` are 1, `mosi`, `busy`, `res_valid` and `res_err` are 0, and the converter is recorded as being in normal mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_chan | input | 2 | Channel to convert |
| req_rng | input | 1 | Range bit placed into the control word |
| req_pm | input | 2 | Power mode to leave the converter in |
| busy | output | 1 | Sequence in progress |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Divided serial clock, idles high |
| mosi | output | 1 | Control word to the converter |
| miso | input | 1 | Conversion word from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_chan | output | 2 | Channel identifier returned by the converter |
| res_data | output | 12 | Conversion result |
| res_err | output | 1 | Leading bits or channel identifier wrong |

## Verification
On every cycle the assertions watch the frame shape and the link timing. They check that `sclk` idles high outside a frame and that each frame has 16 rising `sclk` edges. They check the fall-to-fall and rise-to-fall spacing limits, that chip select is only low while `busy` is high, and that the result strobe and error flag are single-cycle and tied together. The choice between one frame, a dummy frame and a wake frame depends on the power mode programmed by earlier requests. The bench scenarios show this choice, along with the control word contents, the power-up wait after a wake frame, the discarding of dummy data and the error cases. A bench model of the converter decodes the words and returns chosen data.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CTRL_BITS  = 12;

    localparam logic [1:0] PM_AUTO   = 2'b01;
    localparam logic [1:0] PM_FULL   = 2'b10;
    localparam logic [1:0] PM_NORMAL = 2'b11;

    typedef enum logic [1:0] {FK_DUMMY, FK_WAKE, FK_REAL} fkind_e;
    typedef enum logic [1:0] {SQ_IDLE, SQ_WAIT, SQ_RUN} seq_st_e;
    typedef enum logic [1:0] {EN_IDLE, EN_SETUP, EN_LOW, EN_HIGH} eng_st_e;

    typedef struct packed {
        logic       wr;
        logic [1:0] chan;
        logic [1:0] pm;
        logic       rng;
    } ctrl_t;

    typedef struct packed {
        logic [1:0]  lead;
        logic [1:0]  id;
        logic [11:0] data;
    } rx_t;

    function automatic logic [CTRL_BITS-1:0] pack_ctrl(input ctrl_t c);
        return {c.wr, 3'b000, c.chan, c.pm, 2'b00, c.rng, 1'b0};
    endfunction

    function automatic logic rx_bad(input rx_t r, input logic [1:0] want);
        return (r.lead != 2'b00) || (r.id != want);
    endfunction

endpackage

// File: rtl/adc_frame_engine.sv
module adc_frame_engine
    import adc_seq_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [CTRL_BITS-1:0]  ctrl_word,
    output logic                  done,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  cs_n,
    output logic                  sclk,
    output logic                  mosi,
    input  logic                  miso
);

    localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BW = $clog2(FRAME_BITS);
    localparam logic [DW-1:0] DLAST = DW'(HALF - 1);
    localparam logic [BW-1:0] BLAST = BW'(FRAME_BITS - 1);

    eng_st_e               st;
    logic [DW-1:0]         div;
    logic [BW-1:0]         bitc;
    logic [FRAME_BITS-1:0] tx_sr;
    logic [FRAME_BITS-1:0] rx_sr;
    logic                  div_end;

    assign div_end = (div == DLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= EN_IDLE;
            div     <= '0;
            bitc    <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
            cs_n    <= 1'b1;
            sclk    <= 1'b1;
            mosi    <= 1'b0;
            done    <= 1'b0;
            rx_word <= '0;
        end else begin
            done <= 1'b0;
            if (st != EN_IDLE) begin
                div <= div_end ? '0 : div + 1'b1;
            end
            case (st)
                EN_IDLE: begin
                    div <= '0;
                    if (start) begin
                        cs_n  <= 1'b0;
                        tx_sr <= {ctrl_word, {(FRAME_BITS-CTRL_BITS){1'b0}}};
                        st    <= EN_SETUP;
                    end
                end
                EN_SETUP: begin
                    if (div_end) begin
                        sclk  <= 1'b0;
                        mosi  <= tx_sr[FRAME_BITS-1];
                        tx_sr <= tx_sr << 1;
                        bitc  <= '0;
                        st    <= EN_LOW;
                    end
                end
                EN_LOW: begin
                    if (div_end) begin
                        sclk  <= 1'b1;
                        rx_sr <= {rx_sr[FRAME_BITS-2:0], miso};
                        st    <= EN_HIGH;
                    end
                end
                EN_HIGH: begin
                    if (div_end) begin
                        if (bitc == BLAST) begin
                            cs_n    <= 1'b1;
                            mosi    <= 1'b0;
                            done    <= 1'b1;
                            rx_word <= rx_sr;
                            st      <= EN_IDLE;
                        end else begin
                            sclk  <= 1'b0;
                            mosi  <= tx_sr[FRAME_BITS-1];
                            tx_sr <= tx_sr << 1;
                            bitc  <= bitc + 1'b1;
                            st    <= EN_LOW;
                        end
                    end
                end
                default: st <= EN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_gap_timer.sv
module adc_gap_timer #(
    parameter int T_CYC   = 72,
    parameter int T_QUIET = 8,
    parameter int T_PWRUP = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic pwr_wait,
    output logic gap_ok
);

    localparam int TA   = (T_CYC > T_QUIET) ? T_CYC : T_QUIET;
    localparam int TB   = (TA > T_PWRUP) ? TA : T_PWRUP;
    localparam int TMAX = TB + 2;
    localparam int CW   = $clog2(TMAX + 1);
    localparam logic [CW-1:0] CMAX  = CW'(TMAX);
    localparam logic [CW-1:0] L_CYC = CW'(T_CYC);
    localparam logic [CW-1:0] L_QT  = CW'(T_QUIET);
    localparam logic [CW-1:0] L_PU  = CW'(T_PWRUP);
    localparam logic [CW-1:0] SEED  = CW'(2);

    logic          cs_q;
    logic [CW-1:0] cnt_f;
    logic [CW-1:0] cnt_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            cnt_f <= CMAX;
            cnt_r <= CMAX;
        end else begin
            cs_q <= cs_n;
            if (cs_q && !cs_n)       cnt_f <= SEED;
            else if (cnt_f != CMAX)  cnt_f <= cnt_f + 1'b1;
            if (!cs_q && cs_n)       cnt_r <= SEED;
            else if (cnt_r != CMAX)  cnt_r <= cnt_r + 1'b1;
        end
    end

    assign gap_ok = cs_n && cs_q && (cnt_f >= L_CYC) &&
                    (cnt_r >= (pwr_wait ? L_PU : L_QT));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int HALF    = 2,
    parameter int T_CYC   = 72,
    parameter int T_QUIET = 8,
    parameter int T_PWRUP = 40
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [1:0]  req_chan,
    input  logic        req_rng,
    input  logic [1:0]  req_pm,
    output logic        busy,
    output logic        cs_n,
    output logic        sclk,
    output logic        mosi,
    input  logic        miso,
    output logic        res_valid,
    output logic [1:0]  res_chan,
    output logic [11:0] res_data,
    output logic        res_err
);

    seq_st_e               st;
    fkind_e                kind;
    logic [1:0]            cur_pm;
    logic [1:0]            lat_chan;
    logic                  lat_rng;
    logic [1:0]            lat_pm;
    logic                  pwr_wait;
    logic                  gap_ok;
    logic                  f_start;
    logic                  f_done;
    logic [FRAME_BITS-1:0] f_rx;
    ctrl_t                 cw;
    rx_t                   rx;

    always_comb begin
        cw.wr   = (kind != FK_DUMMY);
        cw.chan = lat_chan;
        cw.rng  = lat_rng;
        cw.pm   = (kind == FK_WAKE) ? PM_NORMAL : lat_pm;
    end

    assign rx      = rx_t'(f_rx);
    assign f_start = (st == SQ_WAIT) && gap_ok;
    assign busy    = (st != SQ_IDLE);

    adc_gap_timer #(
        .T_CYC  (T_CYC),
        .T_QUIET(T_QUIET),
        .T_PWRUP(T_PWRUP)
    ) u_gap (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (cs_n),
        .pwr_wait(pwr_wait),
        .gap_ok  (gap_ok)
    );

    adc_frame_engine #(
        .HALF(HALF)
    ) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (f_start),
        .ctrl_word(pack_ctrl(cw)),
        .done     (f_done),
        .rx_word  (f_rx),
        .cs_n     (cs_n),
        .sclk     (sclk),
        .mosi     (mosi),
        .miso     (miso)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= SQ_IDLE;
            kind      <= FK_REAL;
            cur_pm    <= PM_NORMAL;
            lat_chan  <= '0;
            lat_rng   <= 1'b0;
            lat_pm    <= PM_NORMAL;
            pwr_wait  <= 1'b0;
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            res_chan  <= '0;
            res_data  <= '0;
        end else begin
            res_valid <= 1'b0;
            res_err   <= 1'b0;
            case (st)
                SQ_IDLE: begin
                    if (req_valid) begin
                        lat_chan <= req_chan;
                        lat_rng  <= req_rng;
                        lat_pm   <= req_pm;
                        if (cur_pm == PM_AUTO)      kind <= FK_DUMMY;
                        else if (cur_pm == PM_FULL) kind <= FK_WAKE;
                        else                        kind <= FK_REAL;
                        st <= SQ_WAIT;
                    end
                end
                SQ_WAIT: begin
                    if (gap_ok) begin
                        pwr_wait <= 1'b0;
                        st       <= SQ_RUN;
                    end
                end
                SQ_RUN: begin
                    if (f_done) begin
                        case (kind)
                            FK_REAL: begin
                                res_valid <= 1'b1;
                                res_err   <= rx_bad(rx, lat_chan);
                                res_chan  <= rx.id;
                                res_data  <= rx.data;
                                cur_pm    <= lat_pm;
                                st        <= SQ_IDLE;
                            end
                            FK_WAKE: begin
                                cur_pm   <= PM_NORMAL;
                                pwr_wait <= 1'b1;
                                kind     <= FK_REAL;
                                st       <= SQ_WAIT;
                            end
                            default: begin
                                kind <= FK_REAL;
                                st   <= SQ_WAIT;
                            end
                        endcase
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
    parameter int T_CYC   = 72,
    parameter int T_QUIET = 8
) (
    input logic clk,
    input logic rst,
    input logic cs_n,
    input logic sclk,
    input logic busy,
    input logic res_valid,
    input logic res_err
);

    localparam logic [15:0] CMAX = 16'hFFFF;

    logic        cs_p;
    logic        sc_p;
    logic [15:0] since_f;
    logic [15:0] since_r;
    logic [4:0]  rises;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_p    <= 1'b1;
            sc_p    <= 1'b1;
            since_f <= CMAX;
            since_r <= CMAX;
            rises   <= '0;
        end else begin
            cs_p <= cs_n;
            sc_p <= sclk;
            if (cs_p && !cs_n)          since_f <= 16'd1;
            else if (since_f != CMAX)   since_f <= since_f + 16'd1;
            if (!cs_p && cs_n)          since_r <= 16'd1;
            else if (since_r != CMAX)   since_r <= since_r + 16'd1;
            if (cs_p && !cs_n)          rises <= '0;
            else if (!sc_p && sclk)     rises <= rises + 5'd1;
        end
    end

    AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk); // R1
    AST_FRAME_LEN: assert property (@(posedge clk) disable iff (rst)
        (!cs_p && cs_n) |-> (rises == 5'd16)); // R1
    AST_CYC_GAP: assert property (@(posedge clk) disable iff (rst)
        (cs_p && !cs_n) |-> (since_f >= 16'(T_CYC))); // R3
    AST_QUIET_GAP: assert property (@(posedge clk) disable iff (rst)
        (cs_p && !cs_n) |-> (since_r >= 16'(T_QUIET))); // R4
    AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R8
    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        res_err |-> res_valid); // R9
    AST_BUSY_FRAME: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy); // R10

endmodule

bind adc_seq_ctrl adc_seq_chk #(
    .T_CYC  (T_CYC),
    .T_QUIET(T_QUIET)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_n     (cs_n),
    .sclk     (sclk),
    .busy     (busy),
    .res_valid(res_valid),
    .res_err  (res_err)
);

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HALF    = 2;
    localparam int T_CYC   = 72;
    localparam int T_QUIET = 8;
    localparam int T_PWRUP = 40;
    localparam int WD      = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [1:0]  req_chan = '0;
    logic        req_rng = 1'b0;
    logic [1:0]  req_pm = 2'b11;
    logic        busy, cs_n, sclk, mosi;
    logic        miso = 1'b0;
    logic        res_valid, res_err;
    logic [1:0]  res_chan;
    logic [11:0] res_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_seq_ctrl #(.HALF(HALF), .T_CYC(T_CYC), .T_QUIET(T_QUIET), .T_PWRUP(T_PWRUP)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
        .req_rng(req_rng), .req_pm(req_pm), .busy(busy), .cs_n(cs_n),
        .sclk(sclk), .mosi(mosi), .miso(miso), .res_valid(res_valid),
        .res_chan(res_chan), .res_data(res_data), .res_err(res_err)
    );

    int n_chk = 0;
    int n_err = 0;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // converter model: bit k of the reply is placed on miso at the k-th falling sclk edge
    logic [15:0] mword = '0;
    int          mk = 0;
    always @(negedge cs_n) mk = 0;
    always @(negedge sclk) begin
        if (!cs_n && mk < 16) begin
            miso = mword[15-mk];
            mk++;
        end
    end

    // link monitor
    int          cyc = 0;
    logic        cs_p = 1'b1, sc_p = 1'b1;
    int          nfrm = 0;
    int          nbits = 0;
    logic [11:0] sh = '0;
    logic [11:0] fw [4];
    int          ff [4];
    int          fr [4];
    int          fb [4];
    bit          tail_bad = 0;
    int          r_cnt = 0;
    logic [1:0]  r_chan;
    logic [11:0] r_data;
    logic        r_err;

    always @(posedge clk) begin
        cyc++;
        if (!rst) begin
            if (cs_p && !cs_n) begin
                if (nfrm < 4) ff[nfrm] = cyc;
                sh = '0;
                nbits = 0;
            end
            if (!sc_p && sclk && !cs_n) begin
                if (nbits < 12) sh = {sh[10:0], mosi};
                else if (mosi) tail_bad = 1;
                nbits++;
            end
            if (!cs_p && cs_n) begin
                if (nfrm < 4) begin
                    fr[nfrm] = cyc;
                    fw[nfrm] = sh;
                    fb[nfrm] = nbits;
                end
                nfrm++;
            end
            if (res_valid) begin
                r_cnt++;
                r_chan = res_chan;
                r_data = res_data;
                r_err  = res_err;
            end
        end
        cs_p = cs_n;
        sc_p = sclk;
    end

    function automatic logic [11:0] exp_word(input bit wr, input logic [1:0] ch,
                                             input logic [1:0] pm, input bit rng);
        return {wr, 3'b000, ch, pm, 2'b00, rng, 1'b0};
    endfunction

    logic [1:0] bpm = 2'b11;
    bit         have_last = 0;
    int         last_fall = 0;
    int         last_rise = 0;

    task automatic do_req(input logic [1:0] ch, input bit rng, input logic [1:0] pm,
                          input logic [1:0] lead, input logic [1:0] id,
                          input logic [11:0] data, input bit poke);
        int  exp_n;
        int  r0;
        int  t;
        bit  wake;
        bit  e_err;
        exp_n = (bpm == 2'b01 || bpm == 2'b10) ? 2 : 1;
        wake  = (bpm == 2'b10);
        mword = {lead, id, data};
        @(negedge clk);
        t = 0;
        while (busy && t < 5000) begin @(negedge clk); t++; end
        nfrm = 0;
        tail_bad = 0;
        r0 = r_cnt;
        req_chan = ch; req_rng = rng; req_pm = pm; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(busy == 1'b1, "R10 busy after accept", busy, 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            req_chan = ~ch; req_pm = 2'b10; req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0; req_chan = ch; req_pm = pm;
        end
        t = 0;
        while (r_cnt == r0 && t < 3000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        check(r_cnt == r0 + 1, "R8/R10 one result per request", r_cnt - r0, 1);
        check(nfrm == exp_n, "R5/R6/R7 frame count", nfrm, exp_n);
        check(!tail_bad, "R2 mosi low after 12 bits", tail_bad, 0);
        for (int i = 0; i < exp_n && i < nfrm; i++)
            check(fb[i] == 16, "R1 sclk periods per frame", fb[i], 16);
        if (nfrm == exp_n) begin
            check(fw[exp_n-1] == exp_word(1, ch, pm, rng), "R2/R5 control word",
                  fw[exp_n-1], exp_word(1, ch, pm, rng));
            if (exp_n == 2) begin
                if (wake) begin
                    check(fw[0] == exp_word(1, ch, 2'b11, rng), "R7 wake word",
                          fw[0], exp_word(1, ch, 2'b11, rng));
                    check(ff[1] - fr[0] >= T_PWRUP, "R7 power-up gap", ff[1] - fr[0], T_PWRUP);
                end else begin
                    check(fw[0][11] == 1'b0, "R6 dummy write bit", fw[0][11], 0);
                    check(ff[1] - fr[0] >= T_QUIET, "R4 quiet gap", ff[1] - fr[0], T_QUIET);
                end
                check(ff[1] - ff[0] >= T_CYC, "R3 fall spacing", ff[1] - ff[0], T_CYC);
            end
            if (have_last) begin
                check(ff[0] - last_fall >= T_CYC, "R3 fall spacing across requests",
                      ff[0] - last_fall, T_CYC);
                check(ff[0] - last_rise >= T_QUIET, "R4 quiet across requests",
                      ff[0] - last_rise, T_QUIET);
            end
            have_last = 1;
            last_fall = ff[exp_n-1];
            last_rise = fr[exp_n-1];
        end
        e_err = (lead != 2'b00) || (id != ch);
        check(r_chan == id, "R8 result channel id", r_chan, id);
        check(r_data == data, "R8 result data", r_data, data);
        check(r_err == e_err, "R9 error flag", r_err, e_err);
        bpm = pm;
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=0", WD);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check(cs_n == 1'b1 && sclk == 1'b1, "R11 link idle in reset", {cs_n, sclk}, 3);
        rst = 1'b0;
        @(negedge clk);
        check(busy == 0 && res_valid == 0 && mosi == 0 && res_err == 0,
              "R11 outputs quiet after reset", {busy, res_valid, mosi, res_err}, 0);
        // directed corner cases
        do_req(2'd1, 0, 2'b11, 2'b00, 2'd1, 12'hA5C, 0);   // R5 normal
        do_req(2'd2, 1, 2'b11, 2'b00, 2'd2, 12'h0FF, 1);   // R10 ignored request
        do_req(2'd3, 0, 2'b01, 2'b00, 2'd3, 12'h123, 0);   // into auto shutdown
        do_req(2'd0, 1, 2'b01, 2'b00, 2'd0, 12'hFFF, 0);   // R6 dummy frame
        do_req(2'd2, 0, 2'b11, 2'b00, 2'd2, 12'h800, 0);   // R6 leaving auto
        do_req(2'd1, 1, 2'b10, 2'b00, 2'd1, 12'h001, 0);   // into full shutdown
        do_req(2'd3, 1, 2'b11, 2'b00, 2'd3, 12'h7E1, 0);   // R7 wake frame
        do_req(2'd0, 0, 2'b11, 2'b01, 2'd0, 12'h055, 0);   // R9 leading bit
        do_req(2'd2, 0, 2'b11, 2'b00, 2'd1, 12'h3C3, 0);   // R9 wrong id
        // random traffic
        for (int k = 0; k < 40; k++) begin
            logic [1:0]  ch, pm, ld, id;
            logic [11:0] dv;
            bit          rg;
            ch = 2'($urandom_range(0, 3));
            pm = 2'($urandom_range(1, 3));
            rg = 1'($urandom_range(0, 1));
            dv = 12'($urandom());
            ld = 2'b00;
            id = ch;
            if ($urandom_range(0, 5) == 0) ld = 2'($urandom_range(1, 3));
            if ($urandom_range(0, 5) == 0) id = ch ^ 2'($urandom_range(1, 3));
            do_req(ch, rg, pm, ld, id, dv, $urandom_range(0, 3) == 0);
        end
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule